// File: doc/BRIEF.md
# Byte-Lane Synchronous SRAM with Selectable Read Latency

This block is a clocked on-chip memory. Its address, chip enables, write controls and write data are all taken at the rising clock edge. Each word is split into byte lanes, and any subset of those lanes can be written in one cycle. A global write strobe fills the whole word, whatever the per-lane controls say. The storage is written so that it maps onto block RAM, with one bank per byte lane.

A static mode pin selects one of two read paths. In flow-through mode the word read at an edge appears during the next cycle. In pipelined mode it passes through one more output register and appears one cycle later. Which mode a design uses depends on whether it needs the shorter access time or the faster clock.

Deselecting the memory, or issuing a write, releases the output drive with the same latency that a read would take to deliver data. Output enable and the sleep input act at once, without waiting for a clock edge. Sleep also blocks new accesses and keeps every stored word.

Top module: `sync_sram_dp`

## Requirements
- R1: The memory is selected at an edge only when `en_hi_a_i`=1, `en_hi_b_i`=1 and `en_lo_n_i`=0. Any other combination is a deselect cycle: it performs no write and delivers no read data.
- R2: With `pipe_mode_i`=0 (flow-through), a selected read at edge k drives `rd_drive_o`=1 and `rd_data_o` = the stored word. This holds in the cycle after edge k, up to edge k+1.
- R3: With `pipe_mode_i`=1 (pipelined), a selected read at edge k delivers its word in the cycle after edge k+1.
- R4: With `byte_wr_i`=1 and `all_wr_i`=0, a selected cycle writes only the lanes whose `lane_sel_i` bit is 1. Bit i covers data bits [8*i+7:8*i]. The other lanes keep their contents. With both `byte_wr_i` and `all_wr_i` at 0, the cycle is a read and `lane_sel_i` has no effect.
- R5: With `all_wr_i`=1, a selected cycle writes all lanes, whatever the values of `byte_wr_i` and `lane_sel_i`.
- R6: After a deselect cycle, `rd_drive_o` falls with the read latency of the current mode. That is the next cycle in flow-through mode, or one cycle later in pipelined mode.
- R7: While `oe_i`=0, `rd_drive_o`=0 and `rd_data_o`=0 immediately, with no clock edge needed. Output enable does not gate writes.
- R8: While `sleep_i`=1, the outputs are masked immediately (`rd_drive_o`=0, `rd_data_o`=0). Accesses sampled with `sleep_i` high neither write nor read, and all stored words are kept.
- R9: After synchronous reset (`rst`=1 at an edge), `rd_drive_o`=0 and `rd_data_o`=0 until a read is delivered.
- R10: A write cycle produces no read data: `rd_drive_o`=0 in the slot where a read would have been delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | Word address |
| en_hi_a_i | input | 1 | Chip enable, active high |
| en_hi_b_i | input | 1 | Chip enable, active high |
| en_lo_n_i | input | 1 | Chip enable, active low |
| byte_wr_i | input | 1 | Byte write qualifier |
| lane_sel_i | input | DATA_W/8 | Per-lane write select |
| all_wr_i | input | 1 | Global write, all lanes |
| wr_data_i | input | DATA_W | Write data |
| pipe_mode_i | input | 1 | 1 = pipelined, 0 = flow-through |
| oe_i | input | 1 | Asynchronous output enable |
| sleep_i | input | 1 | Asynchronous sleep request |
| rd_data_o | output | DATA_W | Read data, zero when not driven |
| rd_drive_o | output | 1 | Read data is being driven |

## Verification
The bench builds the block with its default parameters: a 32-bit word in four byte lanes and 64 words of depth. At that depth the bench can fill and check every word. Four lanes give sixteen lane-select patterns, so single, partial and empty lane masks can all be tried, and a global write can be shown to override a mask that disagrees with it. The same sequence runs in both latency modes. Mode changes are placed between idle cycles, so each latency and deselect timing is compared against the reference model on every clock.

// File: rtl/sync_sram_pkg.sv
package sync_sram_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } sram_op_e;

  function automatic logic chip_selected(input logic hi_a, input logic hi_b,
                                         input logic lo_n);
    return hi_a & hi_b & ~lo_n;
  endfunction

endpackage

// File: rtl/ssr_cmd_decode.sv
module ssr_cmd_decode
  import sync_sram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             en_hi_a,
  input  logic             en_hi_b,
  input  logic             en_lo_n,
  input  logic             byte_wr,
  input  logic             all_wr,
  input  logic [LANES-1:0] lane_sel,
  input  logic             sleep,
  output sram_op_e         op,
  output logic [LANES-1:0] lane_we
);

  logic selected;
  logic wants_write;

  always_comb begin
    selected    = chip_selected(en_hi_a, en_hi_b, en_lo_n) & ~sleep;
    wants_write = byte_wr | all_wr;
    if (!selected) begin
      op = OP_IDLE;
    end else if (wants_write) begin
      op = OP_WRITE;
    end else begin
      op = OP_READ;
    end
  end

  // the global write wins over the per-lane mask
  always_comb begin
    if (op != OP_WRITE) begin
      lane_we = '0;
    end else if (all_wr) begin
      lane_we = '1;
    end else begin
      lane_we = lane_sel;
    end
  end

endmodule

// File: rtl/ssr_lane_store.sv
module ssr_lane_store #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rd_en,
  input  logic [LANES-1:0]        lane_we,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wr_data,
  output logic [LANES*LANE_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  // one independent bank per lane keeps each a plain block RAM
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] bank [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (lane_we[g]) begin
        bank[addr] <= wr_data[g*LANE_W +: LANE_W];
      end
      if (rd_en) begin
        rd_q <= bank[addr];
      end
    end

    assign rd_data[g*LANE_W +: LANE_W] = rd_q;
  end

endmodule

// File: rtl/ssr_read_path.sv
module ssr_read_path #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_rd,
  input  logic [DATA_W-1:0] mem_data,
  input  logic              pipe_mode,
  input  logic              oe,
  input  logic              sleep,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_drive
);

  logic              s1_valid;
  logic              s2_valid;
  logic [DATA_W-1:0] s2_data;
  logic              sel_valid;
  logic [DATA_W-1:0] sel_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s2_valid <= 1'b0;
      s2_data  <= '0;
    end else begin
      s1_valid <= issue_rd;
      s2_valid <= s1_valid;
      s2_data  <= mem_data;
    end
  end

  always_comb begin
    sel_valid = pipe_mode ? s2_valid : s1_valid;
    sel_data  = pipe_mode ? s2_data  : mem_data;
    rd_drive  = sel_valid & oe & ~sleep;
    rd_data   = rd_drive ? sel_data : '0;
  end

endmodule

// File: rtl/sync_sram_dp.sv
module sync_sram_dp
  import sync_sram_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic                  en_hi_a_i,
  input  logic                  en_hi_b_i,
  input  logic                  en_lo_n_i,
  input  logic                  byte_wr_i,
  input  logic [DATA_W/8-1:0]   lane_sel_i,
  input  logic                  all_wr_i,
  input  logic [DATA_W-1:0]     wr_data_i,
  input  logic                  pipe_mode_i,
  input  logic                  oe_i,
  input  logic                  sleep_i,
  output logic [DATA_W-1:0]     rd_data_o,
  output logic                  rd_drive_o
);

  localparam int LANE_W = 8;
  localparam int LANES  = DATA_W / LANE_W;

  sram_op_e          op;
  logic [LANES-1:0]  lane_we;
  logic [DATA_W-1:0] mem_rd;

  ssr_cmd_decode #(.LANES(LANES)) dec_i (
    .en_hi_a  (en_hi_a_i),
    .en_hi_b  (en_hi_b_i),
    .en_lo_n  (en_lo_n_i),
    .byte_wr  (byte_wr_i),
    .all_wr   (all_wr_i),
    .lane_sel (lane_sel_i),
    .sleep    (sleep_i),
    .op       (op),
    .lane_we  (lane_we)
  );

  ssr_lane_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) store_i (
    .clk     (clk),
    .rd_en   (op == OP_READ),
    .lane_we (lane_we),
    .addr    (addr_i),
    .wr_data (wr_data_i),
    .rd_data (mem_rd)
  );

  ssr_read_path #(.DATA_W(DATA_W)) out_i (
    .clk       (clk),
    .rst       (rst),
    .issue_rd  (op == OP_READ),
    .mem_data  (mem_rd),
    .pipe_mode (pipe_mode_i),
    .oe        (oe_i),
    .sleep     (sleep_i),
    .rd_data   (rd_data_o),
    .rd_drive  (rd_drive_o)
  );

endmodule

// File: rtl/sync_sram_chk.sv
module sync_sram_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              en_hi_a_i,
  input logic              en_hi_b_i,
  input logic              en_lo_n_i,
  input logic              byte_wr_i,
  input logic              all_wr_i,
  input logic              pipe_mode_i,
  input logic              oe_i,
  input logic              sleep_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              rd_drive_o
);

  logic sel_c;
  logic rd_c;
  logic wr_c;
  assign sel_c = en_hi_a_i & en_hi_b_i & ~en_lo_n_i;
  assign rd_c  = sel_c & ~byte_wr_i & ~all_wr_i & ~sleep_i;
  assign wr_c  = sel_c & (byte_wr_i | all_wr_i);

  p_no_sel_out_r1: assert property (@(posedge clk) disable iff (rst)
    (!sel_c && !pipe_mode_i) |=> (pipe_mode_i || !rd_drive_o));

  p_flow_read_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_c && !pipe_mode_i) |=> (pipe_mode_i || !oe_i || sleep_i || rd_drive_o));

  p_pipe_read_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_c && pipe_mode_i) |=> ##1 (!pipe_mode_i || !oe_i || sleep_i || rd_drive_o));

  p_desel_pipe_r6: assert property (@(posedge clk) disable iff (rst)
    (!sel_c && pipe_mode_i) |=> ##1 (!pipe_mode_i || !rd_drive_o));

  p_oe_mask_r7: assert property (@(posedge clk) disable iff (rst)
    !oe_i |-> (!rd_drive_o && rd_data_o == '0));

  p_sleep_mask_r8: assert property (@(posedge clk) disable iff (rst)
    sleep_i |-> (!rd_drive_o && rd_data_o == '0));

  p_reset_quiet_r9: assert property (@(posedge clk)
    rst |=> !rd_drive_o);

  p_write_silent_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_c && !pipe_mode_i) |=> (pipe_mode_i || !rd_drive_o));

endmodule

bind sync_sram_dp sync_sram_chk #(.DATA_W(DATA_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .en_hi_a_i   (en_hi_a_i),
  .en_hi_b_i   (en_hi_b_i),
  .en_lo_n_i   (en_lo_n_i),
  .byte_wr_i   (byte_wr_i),
  .all_wr_i    (all_wr_i),
  .pipe_mode_i (pipe_mode_i),
  .oe_i        (oe_i),
  .sleep_i     (sleep_i),
  .rd_data_o   (rd_data_o),
  .rd_drive_o  (rd_drive_o)
);

// File: tb/sync_sram_dp_tb_top.sv
`timescale 1ns/1ps
module sync_sram_dp_tb_top;
  localparam int DW = 32;
  localparam int AW = 6;
  localparam int NL = DW / 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic en_hi_a_i = 1'b0, en_hi_b_i = 1'b0, en_lo_n_i = 1'b1;
  logic byte_wr_i = 1'b0, all_wr_i = 1'b0;
  logic [NL-1:0] lane_sel_i = '0;
  logic [DW-1:0] wr_data_i = '0;
  logic pipe_mode_i = 1'b0, oe_i = 1'b1, sleep_i = 1'b0;
  logic [DW-1:0] rd_data_o;
  logic rd_drive_o;

  always #4 clk = ~clk;

  sync_sram_dp #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .addr_i(addr_i),
    .en_hi_a_i(en_hi_a_i), .en_hi_b_i(en_hi_b_i), .en_lo_n_i(en_lo_n_i),
    .byte_wr_i(byte_wr_i), .lane_sel_i(lane_sel_i), .all_wr_i(all_wr_i),
    .wr_data_i(wr_data_i), .pipe_mode_i(pipe_mode_i), .oe_i(oe_i),
    .sleep_i(sleep_i), .rd_data_o(rd_data_o), .rd_drive_o(rd_drive_o)
  );

  // behavioural reference: word array plus a two-deep slot history
  logic [DW-1:0] ref_mem [DEPTH];
  bit s1v, s2v;
  logic [DW-1:0] s1d, s2d;
  int nchk = 0, nerr = 0;
  string cur_tag = "R9";

  task automatic compare(input string tag);
    bit ev;
    logic [DW-1:0] ed;
    ev = (pipe_mode_i ? s2v : s1v) && oe_i && !sleep_i;
    ed = ev ? (pipe_mode_i ? s2d : s1d) : '0;
    nchk++;
    if (rd_drive_o !== ev || rd_data_o !== ed) begin
      nerr++;
      $display("FAIL %s t=%0t drive act=%0b exp=%0b data act=%h exp=%h",
               tag, $time, rd_drive_o, ev, rd_data_o, ed);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      s1v = 0; s2v = 0;
    end else begin
      s2v = s1v; s2d = s1d;
      s1v = 0;
      if (!sleep_i && en_hi_a_i && en_hi_b_i && !en_lo_n_i) begin
        if (all_wr_i) begin
          ref_mem[addr_i] = wr_data_i;
        end else if (byte_wr_i) begin
          for (int i = 0; i < NL; i++)
            if (lane_sel_i[i]) ref_mem[addr_i][i*8 +: 8] = wr_data_i[i*8 +: 8];
        end else begin
          s1v = 1; s1d = ref_mem[addr_i];
        end
      end
    end
    #2;
    compare(cur_tag);
  end

  task automatic cyc(input bit a, input bit b, input bit n, input bit bw,
                     input bit aw, input logic [NL-1:0] ls,
                     input logic [AW-1:0] ad, input logic [DW-1:0] d,
                     input string tag);
    @(negedge clk);
    en_hi_a_i = a; en_hi_b_i = b; en_lo_n_i = n;
    byte_wr_i = bw; all_wr_i = aw; lane_sel_i = ls;
    addr_i = ad; wr_data_i = d; cur_tag = tag;
  endtask

  task automatic rd(input logic [AW-1:0] ad, input string tag);
    cyc(1, 1, 0, 0, 0, '0, ad, '0, tag);
  endtask
  task automatic wr_all(input logic [AW-1:0] ad, input logic [DW-1:0] d, input string tag);
    cyc(1, 1, 0, 0, 1, '0, ad, d, tag);
  endtask
  task automatic wr_lanes(input logic [AW-1:0] ad, input logic [NL-1:0] ls,
                          input logic [DW-1:0] d, input string tag);
    cyc(1, 1, 0, 1, 0, ls, ad, d, tag);
  endtask
  task automatic idle(input int k, input string tag);
    for (int i = 0; i < k; i++) cyc(0, 1, 0, 0, 0, '0, '0, '0, tag);
  endtask

  task automatic directed(input string lat);
    // R5: global write overrides a disagreeing lane mask
    for (int i = 0; i < DEPTH; i++) begin
      if (i % 2 == 0) wr_all(i[AW-1:0], 32'hA5000000 + i, "R5");
      else cyc(1, 1, 0, 1, 1, 4'b0000, i[AW-1:0], 32'hA5000000 + i, "R5");
    end
    for (int i = 0; i < 8; i++) rd(i[AW-1:0], lat);
    idle(3, "R6");
    // R4: partial lane masks, including empty and single lanes
    wr_lanes(6'd3, 4'b0101, 32'h11223344, "R4");
    wr_lanes(6'd4, 4'b1000, 32'hDEADBEEF, "R4");
    wr_lanes(6'd5, 4'b0000, 32'hFFFFFFFF, "R4");
    cyc(1, 1, 0, 0, 0, 4'b1111, 6'd6, 32'h0, "R4");
    rd(6'd3, "R4"); rd(6'd4, "R4"); rd(6'd5, "R4");
    // R10: a write between reads leaves an empty slot
    rd(6'd7, lat); wr_all(6'd9, 32'h0BADF00D, "R10"); rd(6'd9, "R10");
    // R1: each enable wrong on its own, including a write attempt
    cyc(0, 1, 0, 0, 1, '0, 6'd10, 32'h1, "R1");
    cyc(1, 0, 0, 0, 1, '0, 6'd11, 32'h2, "R1");
    cyc(1, 1, 1, 0, 1, '0, 6'd12, 32'h3, "R1");
    rd(6'd10, "R1"); rd(6'd11, "R1"); rd(6'd12, "R1");
    // R6: read directly followed by deselect
    rd(6'd1, "R6"); idle(1, "R6"); rd(6'd2, "R6"); idle(3, "R6");
    // R7: output enable removed and restored between edges, writes still land
    rd(6'd2, "R7"); idle(1, "R7");
    @(posedge clk); #2.5; oe_i = 0; #0.5; compare("R7");
    oe_i = 1; #0.5; compare("R7");
    @(negedge clk); oe_i = 0;
    wr_all(6'd13, 32'h77665544, "R7");
    cyc(0, 1, 0, 0, 0, '0, '0, '0, "R7");
    @(negedge clk); oe_i = 1;
    rd(6'd13, "R7"); idle(2, "R7");
    // R8: sleep masks at once, blocks writes, keeps contents
    rd(6'd3, "R8"); rd(6'd4, "R8");
    @(posedge clk); #2.5; sleep_i = 1; #0.5; compare("R8");
    wr_all(6'd3, 32'h0, "R8"); wr_lanes(6'd4, 4'b1111, 32'h0, "R8");
    rd(6'd3, "R8");
    @(negedge clk); sleep_i = 0;
    rd(6'd3, "R8"); rd(6'd4, "R8"); idle(3, "R8");
  endtask

  task automatic random_run(input int n);
    for (int i = 0; i < n; i++) begin
      int k;
      logic [AW-1:0] ad;
      k = $urandom_range(0, 9);
      ad = AW'($urandom_range(0, DEPTH - 1));
      @(negedge clk);
      oe_i = ($urandom_range(0, 7) != 0);
      sleep_i = ($urandom_range(0, 15) == 0);
      case (k)
        0, 1, 2, 3: rd(ad, pipe_mode_i ? "R3" : "R2");
        4: wr_all(ad, $urandom, "R5");
        5, 6: wr_lanes(ad, NL'($urandom), $urandom, "R4");
        7: cyc(1, 1, 1, 0, 0, '0, ad, '0, "R6");
        default: rd(ad, "R2");
      endcase
    end
    @(negedge clk); oe_i = 1; sleep_i = 0;
    idle(3, "R6");
  endtask

  initial begin
    #(8 * 150000);
    nerr++;
    $display("FAIL watchdog all-R act=running exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end

  initial begin
    cur_tag = "R9";
    repeat (3) @(negedge clk);
    rst = 0;
    idle(2, "R9");
    pipe_mode_i = 0;
    directed("R2");
    random_run(400);
    @(negedge clk); pipe_mode_i = 1;
    idle(3, "R3");
    directed("R3");
    random_run(400);
    @(negedge clk); rst = 1; cur_tag = "R9";
    @(negedge clk); rst = 0; idle(3, "R9");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end

endmodule